// File: doc/BRIEF.md
# Streaming Hamming ECC Accumulator

This block sits beside a byte stream moving between a NAND data path and memory. It builds a single-error-correcting Hamming code over every 256-byte chunk without stalling the stream. Column parities track the bit position inside each byte. Line parities track the byte's position inside the chunk. When a chunk is complete, the code is latched into a readable 22-bit word. A formatter then turns that word into the three bytes that are written to the spare area.

Accumulation happens only while the enable input is high. A clear input discards any partial chunk before a new transfer starts. At the end of each chunk the accumulator restarts by itself, so a page of several chunks streams through without software help. Comparing syndromes and correcting errors are left to the consumer of the outputs.

Top module: `hamming_ecc_stream`

## Requirements
- R1: After reset, `ecc_word` is 0, `ecc_done` is 0, and the three stored bytes are 0xFF.
- R2: Bits 5:0 of `ecc_word` are the column parities. For bit-index bit g (g = 0..2), bit 2g is the XOR of all data bits whose bit index has bit g clear. Bit 2g+1 is the XOR of all data bits whose bit index has bit g set. The XOR runs over every byte of the chunk.
- R3: Bits 21:6 of `ecc_word` are the line parities. For byte-index bit k (k = 0..7), bit 6+2k is the XOR of the parities of the bytes whose index has bit k clear. Bit 7+2k is the same over the bytes whose index has bit k set. The byte index is the count of bytes accepted since the last clear or chunk end, starting at 0.
- R4: The 256th accepted byte updates `ecc_word` on the same clock edge that captures it, and `ecc_done` is high for exactly that one cycle.
- R5: After each chunk the accumulator restarts by itself, so each chunk's result depends only on that chunk's bytes.
- R6: A byte presented while `ecc_en` is low is neither counted nor accumulated.
- R7: While `byte_vld` is low, nothing changes.
- R8: `ecc_clr` sets `ecc_word` to 0, discards the partial chunk and resets the byte index to 0. It takes priority over a byte presented in the same cycle.
- R9: The stored form is S = low 24 bits of ~(ecc_word << 2). `store_b0` = S[23:16], `store_b1` = S[15:8] and `store_b2` = S[7:0]. The stored bytes follow `ecc_word` one cycle later.
- R10: Flipping data bit b of byte i changes `ecc_word` by exactly the following bits: bit 2g+b[g] for each g, and bit 6+2k+i[k] for each k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | Accumulation enable |
| ecc_clr | input | 1 | Clear the accumulated code and the byte index |
| byte_vld | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| ecc_word | output | 22 | Latched code: line parity above column parity |
| ecc_done | output | 1 | One-cycle pulse when a chunk result is latched |
| store_b0 | output | 8 | Stored byte 0, most significant |
| store_b1 | output | 8 | Stored byte 1 |
| store_b2 | output | 8 | Stored byte 2, least significant |

## Verification
The bench builds the block with its default parameters: 256-byte chunks, 8-bit data and 3 stored bytes. With these values, all eight line-parity pairs and all three column-parity pairs are exercised by real chunk traffic. Random chunks with idle and disabled gaps are mixed with directed cases: a single set bit, a clear in the middle of a chunk that collides with a byte, a disabled byte just before the chunk boundary, and a single flipped bit whose code difference must point to the byte and bit that were flipped.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  localparam int STORE_SHIFT = 2;
  localparam int BYTE_W      = 8;

  function automatic int pair_w(input int n);
    return 2 * $clog2(n);
  endfunction
endpackage

// File: rtl/hecc_byte_term.sv
module hecc_byte_term #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8,
  localparam int BIT_IDX_W = $clog2(DATA_W),
  localparam int COL_W  = 2 * BIT_IDX_W,
  localparam int LINE_W = 2 * IDX_W
) (
  input  logic [DATA_W-1:0] data,
  input  logic [IDX_W-1:0]  idx,
  output logic [COL_W-1:0]  col_term,
  output logic [LINE_W-1:0] line_term
);
  logic byte_par;
  assign byte_par = ^data;

  // column parity: one even/odd pair per bit of the bit index
  always_comb begin
    col_term = '0;
    for (int g = 0; g < BIT_IDX_W; g++) begin
      for (int b = 0; b < DATA_W; b++) begin
        if (((b >> g) & 1) != 0) col_term[2*g+1] = col_term[2*g+1] ^ data[b];
        else                     col_term[2*g]   = col_term[2*g]   ^ data[b];
      end
    end
  end

  // line parity: byte parity steered by each byte-index bit
  for (genvar k = 0; k < IDX_W; k++) begin : g_line
    assign line_term[2*k]   = byte_par & ~idx[k];
    assign line_term[2*k+1] = byte_par &  idx[k];
  end
endmodule

// File: rtl/hecc_accum.sv
module hecc_accum #(
  parameter int CHUNK_BYTES = 256,
  parameter int COL_W = 6,
  localparam int IDX_W  = $clog2(CHUNK_BYTES),
  localparam int LINE_W = 2 * IDX_W,
  localparam int ECC_W  = COL_W + LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  logic [COL_W-1:0]  col_term,
  input  logic [LINE_W-1:0] line_term,
  output logic [IDX_W-1:0]  idx,
  output logic [ECC_W-1:0]  word_q,
  output logic              done_q
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CHUNK_BYTES - 1);

  logic [COL_W-1:0]  acc_col;
  logic [LINE_W-1:0] acc_line;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx      <= '0;
      acc_col  <= '0;
      acc_line <= '0;
      word_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        if (idx == LAST) begin
          word_q   <= {acc_line ^ line_term, acc_col ^ col_term};
          done_q   <= 1'b1;
          acc_col  <= '0;
          acc_line <= '0;
          idx      <= '0;
        end else begin
          acc_col  <= acc_col ^ col_term;
          acc_line <= acc_line ^ line_term;
          idx      <= idx + 1'b1;
        end
      end
    end
  end

  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  p_done_after_take_r4: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ($past(take) && idx == '0));
  p_clr_restart_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (idx == '0 && word_q == '0 && !done_q));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!take && !clr) |=> ($stable(word_q) && $stable(idx) && $stable(acc_col) && $stable(acc_line)));
endmodule

// File: rtl/hecc_store_fmt.sv
module hecc_store_fmt #(
  parameter int ECC_W = 22,
  parameter int STORE_BYTES = 3,
  localparam int STORE_W = 8 * STORE_BYTES
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ECC_W-1:0]            word,
  output logic [STORE_BYTES-1:0][7:0] store_q
);
  logic [STORE_W-1:0] shifted;
  logic [STORE_W-1:0] inverted;

  assign shifted  = STORE_W'({word, {hecc_pkg::STORE_SHIFT{1'b0}}});
  assign inverted = ~shifted;

  // byte 0 carries the most significant bits
  for (genvar j = 0; j < STORE_BYTES; j++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) store_q[j] <= 8'hFF;
      else     store_q[j] <= inverted[STORE_W-1-8*j -: 8];
    end
  end

  p_reset_form_r1: assert property (@(posedge clk)
    rst |=> (store_q == '1));
endmodule

// File: rtl/hamming_ecc_stream.sv
module hamming_ecc_stream #(
  parameter int CHUNK_BYTES = 256,
  parameter int DATA_W = 8,
  localparam int IDX_W  = $clog2(CHUNK_BYTES),
  localparam int COL_W  = hecc_pkg::pair_w(DATA_W),
  localparam int LINE_W = 2 * IDX_W,
  localparam int ECC_W  = COL_W + LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ecc_en,
  input  logic              ecc_clr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  output logic [ECC_W-1:0]  ecc_word,
  output logic              ecc_done,
  output logic [7:0]        store_b0,
  output logic [7:0]        store_b1,
  output logic [7:0]        store_b2
);
  localparam int STORE_BYTES = 3;
  localparam int NPAIR = ECC_W / 2;

  logic [IDX_W-1:0]  idx;
  logic [COL_W-1:0]  col_term;
  logic [LINE_W-1:0] line_term;
  logic              take;
  logic [STORE_BYTES-1:0][7:0] store_q;

  assign take = byte_vld & ecc_en & ~ecc_clr;

  hecc_byte_term #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_term (
    .data(byte_data), .idx(idx), .col_term(col_term), .line_term(line_term));

  hecc_accum #(.CHUNK_BYTES(CHUNK_BYTES), .COL_W(COL_W)) i_accum (
    .clk(clk), .rst(rst), .clr(ecc_clr), .take(take),
    .col_term(col_term), .line_term(line_term),
    .idx(idx), .word_q(ecc_word), .done_q(ecc_done));

  hecc_store_fmt #(.ECC_W(ECC_W), .STORE_BYTES(STORE_BYTES)) i_fmt (
    .clk(clk), .rst(rst), .word(ecc_word), .store_q(store_q));

  assign store_b0 = store_q[0];
  assign store_b1 = store_q[1];
  assign store_b2 = store_q[2];

  // every even/odd pair sums to the total parity of the chunk
  logic [NPAIR-1:0] pair_x;
  always_comb
    for (int k = 0; k < NPAIR; k++) pair_x[k] = ecc_word[2*k] ^ ecc_word[2*k+1];

  p_pair_parity_r3: assert property (@(posedge clk) disable iff (rst)
    ecc_done |-> (pair_x == '0 || pair_x == '1));
  p_off_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (!ecc_en && !ecc_clr) |=> ($stable(ecc_word) && !ecc_done));
endmodule

// File: tb/test_hamming_ecc_stream.sv
module test_hamming_ecc_stream;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ecc_en = 1'b0, ecc_clr = 1'b0, byte_vld = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [21:0] ecc_word;
  logic ecc_done;
  logic [7:0] store_b0, store_b1, store_b2;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] mem [256];

  always #5 clk = ~clk;

  hamming_ecc_stream i_hamming_ecc_stream (
    .clk(clk), .rst(rst), .ecc_en(ecc_en), .ecc_clr(ecc_clr),
    .byte_vld(byte_vld), .byte_data(byte_data), .ecc_word(ecc_word),
    .ecc_done(ecc_done), .store_b0(store_b0), .store_b1(store_b1),
    .store_b2(store_b2));

  function automatic logic [21:0] model_ecc();
    logic [5:0] c = '0;
    logic [15:0] l = '0;
    for (int i = 0; i < 256; i++) begin
      for (int b = 0; b < 8; b++)
        for (int g = 0; g < 3; g++)
          if (((b >> g) & 1) != 0) c[2*g+1] ^= mem[i][b];
          else                     c[2*g]   ^= mem[i][b];
      for (int k = 0; k < 8; k++)
        if (((i >> k) & 1) != 0) l[2*k+1] ^= ^mem[i];
        else                     l[2*k]   ^= ^mem[i];
    end
    return {l, c};
  endfunction

  function automatic logic [23:0] model_store(input logic [21:0] w);
    return ~{w, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic e, input logic c, input logic [7:0] d);
    @(negedge clk);
    byte_vld = v; ecc_en = e; ecc_clr = c; byte_data = d;
  endtask

  // feed mem[0..255]; optional random gaps; when hold255, a disabled byte precedes the last one
  task automatic feed_chunk(input bit gaps, input bit hold255);
    for (int i = 0; i < 256; i++) begin
      if (gaps && ($urandom % 6) == 0) drive(1'b0, 1'b1, 1'b0, 8'($urandom));
      if (gaps && ($urandom % 6) == 0) drive(1'b1, 1'b0, 1'b0, 8'($urandom));
      if (hold255 && i == 255) begin
        drive(1'b1, 1'b0, 1'b0, 8'h5A);
        drive(1'b0, 1'b1, 1'b0, 8'h00);
        chk(ecc_done == 1'b0, "R6 disabled byte must not finish chunk", 32'(ecc_done), 32'd0);
      end
      drive(1'b1, 1'b1, 1'b0, mem[i]);
    end
  endtask

  // after the last byte: result and done on next negedge, stored bytes one later
  task automatic check_result(input string tag, output logic [21:0] got);
    logic [21:0] exp;
    exp = model_ecc();
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    chk(ecc_done == 1'b1, {tag, " R4 done pulse"}, 32'(ecc_done), 32'd1);
    chk(ecc_word == exp, {tag, " R2 R3 code word"}, 32'(ecc_word), 32'(exp));
    got = ecc_word;
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    chk(ecc_done == 1'b0, {tag, " R4 single cycle done"}, 32'(ecc_done), 32'd0);
    chk({store_b0, store_b1, store_b2} == model_store(exp), {tag, " R9 stored bytes"},
        32'({store_b0, store_b1, store_b2}), 32'(model_store(exp)));
  endtask

  initial begin
    repeat (3000000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [21:0] wa, wb, dexp;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(ecc_word == '0, "R1 reset word", 32'(ecc_word), 32'd0);
    chk(ecc_done == 1'b0, "R1 reset done", 32'(ecc_done), 32'd0);
    chk({store_b0, store_b1, store_b2} == 24'hFFFFFF, "R1 reset stored",
        32'({store_b0, store_b1, store_b2}), 32'hFFFFFF);

    // directed: one set bit in byte 0
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[0] = 8'h01;
    feed_chunk(1'b0, 1'b0);
    check_result("single-bit", wa);
    chk(wa == 22'h15_5555 >> 0 ? 1'b1 : (wa == {16'h5555, 6'h15}), "R2 R3 directed value",
        32'(wa), 32'({16'h5555, 6'h15}));

    // random chunks back to back, with gaps (R5, R7)
    for (int n = 0; n < 3; n++) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
      feed_chunk(1'b1, 1'b0);
      check_result("R5 random", wa);
    end

    // disabled byte right before the last byte (R6)
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    feed_chunk(1'b1, 1'b1);
    check_result("R6 gated", wa);

    // clear mid chunk colliding with a byte (R8)
    for (int i = 0; i < 100; i++) drive(1'b1, 1'b1, 1'b0, 8'($urandom));
    drive(1'b1, 1'b1, 1'b1, 8'hFF);
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    chk(ecc_word == '0, "R8 clear zeroes word", 32'(ecc_word), 32'd0);
    chk(ecc_done == 1'b0, "R8 no done on clear", 32'(ecc_done), 32'd0);
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    feed_chunk(1'b0, 1'b0);
    check_result("R8 after clear", wa);

    // single flipped bit locates byte and bit (R10)
    mem[8'hA5] = mem[8'hA5] ^ 8'h40;
    feed_chunk(1'b1, 1'b0);
    check_result("R10 flipped", wb);
    dexp = '0;
    for (int g = 0; g < 3; g++) dexp[2*g + ((6 >> g) & 1)] = 1'b1;
    for (int k = 0; k < 8; k++) dexp[6 + 2*k + ((8'hA5 >> k) & 1)] = 1'b1;
    chk((wa ^ wb) == dexp, "R10 syndrome position", 32'(wa ^ wb), 32'(dexp));

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule